// File: doc/BRIEF.md
# Gated Up-Down Pulse-Width Net Counter

This block is the digital half of a modulated pulse-width voltmeter. Two comparator gates arrive on single-bit inputs. One marks the intervals in which the positive reference is applied and the other marks the intervals for the negative reference. A signed accumulator runs on the fast reference clock. It adds one for every cycle the positive gate is high and subtracts one for every cycle the negative gate is high. The net count is therefore proportional to the input voltage.

A period-start strobe marks the first cycle of each modulation period. The block groups a programmable number of whole periods into one integration window. A window of many periods averages out line-frequency ripple and noise. At the end of each window the net count is copied to a result register, and a one-cycle valid strobe is raised with it. Counting carries on into the next window without a gap. When the input is zero the two gate widths match, so the result is zero.

All three strobe and gate inputs pass through the same two-flop synchroniser, so they keep their relative timing.

Top module: `pwm_netcount_acc`

## Requirements
- R1: A reference-clock cycle in which only the positive gate is high adds exactly one to the running count.
- R2: A cycle in which only the negative gate is high subtracts exactly one from the running count.
- R3: A cycle in which both gates are high, or neither gate is high, leaves the running count unchanged.
- R4: When every period has equal positive and negative gate widths, each window result is zero.
- R5: The first period-start after reset opens the first window, and gate activity before it is discarded. After that, a window holds `win_periods_i` whole periods, and a setting of 0 behaves as 1.
- R6: A window closes at the period-start that begins the next window. In that cycle `result_o` is loaded with the net count of the window and `result_valid_o` is high. The gate sample of the period-start cycle becomes the first count of the new window, so no count is lost.
- R7: The running count saturates at the most positive and most negative `ACC_W`-bit two's-complement values. Leaving that range sets `overflow_o`, and the flag stays set until reset.
- R8: Reset clears `result_o`, `result_valid_o` and `overflow_o` to zero.
- R9: Every input passes through two synchroniser flops. For a window-closing period-start that is sampled at clock edge k, `result_valid_o` rises at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| gate_pos_i | input | 1 | Positive-reference gate from its comparator |
| gate_neg_i | input | 1 | Negative-reference gate from its comparator |
| period_start_i | input | 1 | High for the first cycle of each modulation period |
| win_periods_i | input | PER_W | Number of whole periods per window (0 behaves as 1) |
| result_o | output | ACC_W | Signed net count of the last completed window |
| result_valid_o | output | 1 | One-cycle strobe marking a new result |
| overflow_o | output | 1 | Sticky flag for saturation of the running count |

## Verification
The bench goes after these corner cases:

- **Gate activity before the first period-start.** A design that counted it would report a first window that is offset by the discarded cycles.
- **Windows of a single period, including periods only one cycle long.** Here valid strobes come back to back. A design that dropped the sample of the period-start cycle, or counted it twice, would be off by one in every result.
- **Cycles where both gates are high, and periods with equal gate widths.** These must give a net zero. A design that favoured one gate would drift away from zero.
- **Pushing the count past both signed limits.** A design without saturation would wrap to the opposite sign. A design whose flag was not sticky would clear the flag once the count came back into range.

// File: rtl/pwm_netcount_acc.sv
module pwm_netcount_acc #(
  parameter int ACC_W = 20,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_pos_i,
  input  logic             gate_neg_i,
  input  logic             period_start_i,
  input  logic [PER_W-1:0] win_periods_i,
  output logic [ACC_W-1:0] result_o,
  output logic             result_valid_o,
  output logic             overflow_o
);

  localparam logic [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W:0]   ONE  = {{ACC_W{1'b0}}, 1'b1};
  localparam logic [ACC_W:0]   MONE = {(ACC_W+1){1'b1}};

  logic [1:0] pos_sy, neg_sy, ps_sy;
  logic       pos, neg, ps;
  logic       armed;
  logic [PER_W-1:0] per_cnt;
  logic [PER_W-1:0] n_eff;
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   step;
  logic [ACC_W:0]   sum;
  logic             hi_ovf, lo_ovf;
  logic             wend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_sy <= '0;
      neg_sy <= '0;
      ps_sy  <= '0;
    end else begin
      pos_sy <= {pos_sy[0], gate_pos_i};
      neg_sy <= {neg_sy[0], gate_neg_i};
      ps_sy  <= {ps_sy[0], period_start_i};
    end
  end

  assign pos = pos_sy[1];
  assign neg = neg_sy[1];
  assign ps  = ps_sy[1];

  assign step   = (pos && !neg) ? ONE : ((neg && !pos) ? MONE : '0);
  assign sum    = {acc[ACC_W-1], acc} + step;
  assign hi_ovf = !sum[ACC_W] && sum[ACC_W-1];
  assign lo_ovf = sum[ACC_W] && !sum[ACC_W-1];

  assign n_eff = (win_periods_i == '0) ? {{(PER_W-1){1'b0}}, 1'b1} : win_periods_i;
  assign wend  = ps && armed && (({1'b0, per_cnt} + 1'b1) >= {1'b0, n_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed          <= 1'b0;
      per_cnt        <= '0;
      acc            <= '0;
      result_o       <= '0;
      result_valid_o <= 1'b0;
      overflow_o     <= 1'b0;
    end else begin
      result_valid_o <= wend;
      if (ps && !armed) begin
        armed   <= 1'b1;
        per_cnt <= '0;
        acc     <= step[ACC_W-1:0];
      end else if (wend) begin
        per_cnt  <= '0;
        result_o <= acc;
        acc      <= step[ACC_W-1:0];
      end else if (armed) begin
        if (ps) per_cnt <= per_cnt + 1'b1;
        if (hi_ovf) begin
          acc        <= MAXV;
          overflow_o <= 1'b1;
        end else if (lo_ovf) begin
          acc        <= MINV;
          overflow_o <= 1'b1;
        end else begin
          acc <= sum[ACC_W-1:0];
        end
      end
    end
  end

  a_r1_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ps && pos && !neg && acc != MAXV) |=> (acc - $past(acc)) == ONE[ACC_W-1:0]);

  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ps && neg && !pos && acc != MINV) |=> ($past(acc) - acc) == ONE[ACC_W-1:0]);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ps && (pos == neg)) |=> $stable(acc));

  a_r5_idle_until_start: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (acc == '0 && !result_valid_o));

  a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid_o |-> $stable(result_o));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  a_r9_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> $past(ps));

endmodule

// File: tb/pwm_netcount_acc_tb.sv
module pwm_netcount_acc_tb_top;
  localparam int ACC_W = 12;
  localparam int PER_W = 4;
  localparam int MAXV  = (1 << (ACC_W-1)) - 1;
  localparam int MINV  = -(1 << (ACC_W-1));

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             gate_pos_i = 1'b0;
  logic             gate_neg_i = 1'b0;
  logic             period_start_i = 1'b0;
  logic [PER_W-1:0] win_periods_i = '0;
  logic [ACC_W-1:0] result_o;
  logic             result_valid_o;
  logic             overflow_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  int q_val[$];
  int q_cyc[$];
  string q_req[$];

  bit m_armed;
  int m_cnt, m_acc, m_n;
  string cur_req;

  pwm_netcount_acc #(.ACC_W(ACC_W), .PER_W(PER_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .gate_pos_i(gate_pos_i), .gate_neg_i(gate_neg_i),
    .period_start_i(period_start_i), .win_periods_i(win_periods_i),
    .result_o(result_o), .result_valid_o(result_valid_o), .overflow_o(overflow_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && result_valid_o) begin
      if (q_val.size() == 0) begin
        check("R6 unexpected valid", 1, 0);
      end else begin
        int ev, ec;
        string rq;
        ev = q_val.pop_front();
        ec = q_cyc.pop_front();
        rq = q_req.pop_front();
        check({rq, " window result"}, int'($signed(result_o)), ev);
        check("R9 result latency", cyc, ec);
      end
    end
  end

  task automatic do_reset(input int n);
    @(negedge clk);
    rst_n = 1'b0;
    gate_pos_i = 1'b0;
    gate_neg_i = 1'b0;
    period_start_i = 1'b0;
    win_periods_i = PER_W'(n);
    q_val.delete();
    q_cyc.delete();
    q_req.delete();
    m_armed = 1'b0;
    m_cnt = 0;
    m_acc = 0;
    m_n = (n == 0) ? 1 : n;
    repeat (3) @(negedge clk);
    check("R8 reset result", int'(result_o), 0);
    check("R8 reset valid", int'(result_valid_o), 0);
    check("R8 reset overflow", int'(overflow_o), 0);
    rst_n = 1'b1;
  endtask

  function automatic int sat(input int v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic drive_cyc(input bit p, input bit ng, input bit s);
    int st;
    @(negedge clk);
    gate_pos_i = p;
    gate_neg_i = ng;
    period_start_i = s;
    st = (p && !ng) ? 1 : ((ng && !p) ? -1 : 0);
    if (s && !m_armed) begin
      m_armed = 1'b1;
      m_cnt = 0;
      m_acc = st;
    end else if (s && (m_cnt + 1 >= m_n)) begin
      q_val.push_back(m_acc);
      q_cyc.push_back(cyc + 3);
      q_req.push_back(cur_req);
      m_cnt = 0;
      m_acc = st;
    end else if (m_armed) begin
      if (s) m_cnt++;
      m_acc = sat(m_acc + st);
    end
  endtask

  task automatic drive_period(input int a, input int b, input int c, input int d);
    int k;
    k = 0;
    for (int i = 0; i < a; i++) begin drive_cyc(1, 0, k == 0); k++; end
    for (int i = 0; i < b; i++) begin drive_cyc(0, 1, k == 0); k++; end
    for (int i = 0; i < c; i++) begin drive_cyc(1, 1, k == 0); k++; end
    for (int i = 0; i < d; i++) begin drive_cyc(0, 0, k == 0); k++; end
  endtask

  task automatic drain;
    drive_period(0, 0, 0, 1);
    repeat (6) drive_cyc(0, 0, 0);
    check("R6 all results seen", q_val.size(), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 R2 R3 R5: discarded activity before first start, two-period windows
    do_reset(2);
    cur_req = "R5";
    for (int i = 0; i < 10; i++) drive_cyc(1, 0, 0);
    cur_req = "R1 R2 R3";
    drive_period(30, 10, 5, 5);
    drive_period(8, 20, 0, 4);
    drive_period(0, 7, 2, 1);
    drive_period(12, 0, 0, 0);
    drain();

    // R4: equal widths give zero
    do_reset(3);
    cur_req = "R4";
    for (int w = 0; w < 2; w++) begin
      drive_period(25, 25, 3, 2);
      drive_period(40, 40, 0, 6);
      drive_period(1, 1, 9, 0);
    end
    drain();

    // R5 R6: setting 0 acts as 1, back-to-back short periods
    do_reset(0);
    cur_req = "R6";
    drive_period(1, 0, 0, 0);
    drive_period(0, 1, 0, 0);
    drive_period(1, 0, 0, 0);
    drive_period(0, 0, 1, 0);
    drive_period(3, 1, 0, 0);
    drive_period(0, 0, 0, 1);
    drive_period(2, 5, 1, 0);
    drain();

    // R7: positive then negative saturation, sticky flag
    do_reset(1);
    cur_req = "R7 positive";
    drive_period(MAXV + 40, 0, 0, 0);
    drive_period(0, 0, 0, 2);
    repeat (3) drive_cyc(0, 0, 0);
    check("R7 overflow set", int'(overflow_o), 1);
    cur_req = "R7 negative";
    drive_period(0, 10, 0, 0);
    drive_period(0, -MINV + 30, 0, 0);
    drain();
    check("R7 overflow sticky", int'(overflow_o), 1);

    do_reset(1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule